// File: doc/BRIEF.md
# Dual Clock Activity Watchdog

This block watches a pair of unrelated clocks, a transmit clock and a receive clock, and each clock acts as the timebase that judges whether the other one is still running. A monitored clock counts as lost when no rising edge of it reaches the reference domain for a set number of reference periods. The resulting alarm is a plain level held in the reference domain. It drops again as soon as a single edge of the monitored clock gets through.

In the monitored domain, a flop toggles on every rising edge. The toggle crosses into the reference domain through a synchronizer of configurable depth. There it is compared with its last sampled value. A counter tracks reference cycles since the last observed change and stops at the limit. The alarm is set when the counter reaches the limit. Both directions use the same logic, so the block is symmetric.

Top module: `xclk_loss_mon`

## Requirements
- R1: After the transmit clock stops, `tx_clk_lost` (receive domain) stays 0 for at least LOSS_LIMIT (default 10) receive rising edges after the last transmit rising edge. It is 1 once LOSS_LIMIT+SYNC_STAGES+3 receive rising edges have passed.
- R2: The same rule applies in the other direction. `rx_clk_lost` (transmit domain) stays 0 for at least LOSS_LIMIT transmit rising edges after the last receive rising edge. It is 1 once LOSS_LIMIT+SYNC_STAGES+3 transmit rising edges have passed.
- R3: While the monitored clock keeps running, its alarm stays 0. This includes pauses of at most LOSS_LIMIT-3 reference periods.
- R4: A raised alarm returns to 0 within SYNC_STAGES+3 reference rising edges after the first rising edge of the restarted monitored clock.
- R5: While the monitored clock stays stopped, the alarm stays 1 for any length of stall, because the internal period count saturates at LOSS_LIMIT.
- R6: While `rst_n` is 0 at a reference rising edge, the alarm of that domain is 0 after that edge. Reset is synchronous and active low in each domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tx_clk | input | 1 | Transmit clock; reference for `rx_clk_lost`, monitored by the receive side |
| rx_clk | input | 1 | Receive clock; reference for `tx_clk_lost`, monitored by the transmit side |
| rst_n | input | 1 | Active-low reset, sampled synchronously in both domains |
| tx_clk_lost | output | 1 | Receive-domain level, 1 while the transmit clock is judged lost |
| rx_clk_lost | output | 1 | Transmit-domain level, 1 while the receive clock is judged lost |

## Verification
The assertions assume the following:
- `rst_n` is held low across several edges of the reference clock they are clocked by.
- The monitored clock runs at less than twice the reference frequency, so two toggles cannot fall between two reference samples and hide each other for long.

The stimulus uses fixed, unrelated periods of 10 ns and 13 ns. Every stall starts just after a rising edge of the monitored clock and stops only that clock, so the reference never pauses. Random stall lengths are drawn to lie either clearly below the no-alarm bound or beyond the must-alarm bound. The cycles between those bounds, where synchronizer phase decides the outcome, are never compared.

// File: rtl/xclm_pkg.sv
// Package: shared helpers for the dual clock activity watchdog.
// Assumes limits are at least 1.
package xclm_pkg;

    // Width needed to hold a period count from 0 up to limit inclusive.
    function automatic int cnt_width(input int limit);
        return (limit < 1) ? 1 : $clog2(limit + 1);
    endfunction

    // Reference cycles from a monitored edge until the counter restarts:
    // the synchronizer stages plus the previous-sample register.
    function automatic int detect_latency(input int stages);
        return stages + 1;
    endfunction

endpackage

// File: rtl/xclm_toggle.sv
// Module: xclm_toggle
// Flips its output on every rising edge of the monitored clock.
// This gives the reference domain one level change per monitored period.
// Assumes rst_n is synchronous and active low; if the clock is stopped,
// the reset simply does not take effect in this domain.
module xclm_toggle (
    input  logic clk,
    input  logic rst_n,
    output logic tgl_o
);

    logic tgl_q;

    // Activity toggle: one inversion per monitored rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) tgl_q <= 1'b0;
        else        tgl_q <= ~tgl_q;
    end

    assign tgl_o = tgl_q;

endmodule

// File: rtl/xclm_sync.sv
// Module: xclm_sync
// Multi-flop synchronizer that brings one level into the clk domain.
// Assumes STAGES >= 2 and a slowly changing input (a toggle).
module xclm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] pipe_q;

    // Shift stage: first flop captures the asynchronous level.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q[0] <= 1'b0;
        else        pipe_q[0] <= d_i;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        // Shift stage: each later flop resolves metastability further.
        always_ff @(posedge clk) begin
            if (!rst_n) pipe_q[g] <= 1'b0;
            else        pipe_q[g] <= pipe_q[g-1];
        end
    end

    assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/xclm_watch.sv
// Module: xclm_watch
// Runs in the reference domain. It synchronizes a monitored toggle,
// detects a change against the last sample, and counts reference cycles
// without a change, saturating at LIMIT. Lost is high while the count
// sits at LIMIT. One observed change clears the count and the alarm.
// Assumes the monitored clock is under twice the reference frequency.
module xclm_watch
    import xclm_pkg::*;
#(
    parameter int LIMIT  = 10,
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tgl_i,
    output logic lost_o
);

    localparam int CW = cnt_width(LIMIT);
    localparam logic [CW-1:0] CNT_MAX = CW'(LIMIT);

    logic          tgl_sync;
    logic          prev_q;
    logic          change;
    logic [CW-1:0] cnt_q;
    logic          lost_q;

    xclm_sync #(.STAGES(STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (tgl_i),
        .q_o   (tgl_sync)
    );

    // Previous sample of the synchronized toggle, for change detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= tgl_sync;
    end

    assign change = tgl_sync ^ prev_q;

    // Quiet-period counter and alarm: restart on change, else count up to LIMIT.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            lost_q <= 1'b0;
        end else if (change) begin
            cnt_q  <= '0;
            lost_q <= 1'b0;
        end else if (cnt_q != CNT_MAX) begin
            cnt_q  <= cnt_q + CW'(1);
            lost_q <= (cnt_q + CW'(1)) == CNT_MAX;
        end else begin
            lost_q <= 1'b1;
        end
    end

    assign lost_o = lost_q;

    // R5: the quiet count never passes its ceiling.
    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_MAX);

    // R5: with no change seen, a raised alarm stays raised.
    assert_alarm_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (lost_q && !change) |=> lost_q);

    // R4: an observed toggle change clears the alarm on the next edge.
    assert_clear_on_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        change |=> !lost_q);

    // R3: the alarm only rises after a full quiet window with no change.
    assert_no_early_alarm_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lost_q) |-> (!$past(change) && $past(cnt_q) == CNT_MAX - CW'(1)));

    // R6: reset seen at an edge leaves the alarm low afterwards.
    assert_reset_clear_R6: assert property (@(posedge clk)
        !rst_n |=> !lost_q);

endmodule

// File: rtl/xclk_loss_mon.sv
// Module: xclk_loss_mon
// Symmetric loss-of-clock monitor. Each clock toggles a flop in its own
// domain, and the other clock watches that toggle with an xclm_watch.
// tx_clk_lost lives in the rx_clk domain; rx_clk_lost lives in tx_clk.
// Assumes rst_n is held low over several edges of both clocks and that
// the two clock frequencies are within a factor of two of each other.
module xclk_loss_mon #(
    parameter int LOSS_LIMIT  = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic tx_clk,
    input  logic rx_clk,
    input  logic rst_n,
    output logic tx_clk_lost,
    output logic rx_clk_lost
);

    logic tx_tgl;
    logic rx_tgl;

    // Transmit-domain activity toggle, watched from the receive domain.
    xclm_toggle u_tx_tgl (
        .clk   (tx_clk),
        .rst_n (rst_n),
        .tgl_o (tx_tgl)
    );

    // Receive-domain activity toggle, watched from the transmit domain.
    xclm_toggle u_rx_tgl (
        .clk   (rx_clk),
        .rst_n (rst_n),
        .tgl_o (rx_tgl)
    );

    // Receive clock judges the transmit clock.
    xclm_watch #(.LIMIT(LOSS_LIMIT), .STAGES(SYNC_STAGES)) u_watch_tx (
        .clk    (rx_clk),
        .rst_n  (rst_n),
        .tgl_i  (tx_tgl),
        .lost_o (tx_clk_lost)
    );

    // Transmit clock judges the receive clock.
    xclm_watch #(.LIMIT(LOSS_LIMIT), .STAGES(SYNC_STAGES)) u_watch_rx (
        .clk    (tx_clk),
        .rst_n  (rst_n),
        .tgl_i  (rx_tgl),
        .lost_o (rx_clk_lost)
    );

endmodule

// File: tb/xclk_loss_mon_bench.sv
`timescale 1ns/1ps
module xclk_loss_mon_bench;

    localparam int          LIMIT     = 10;
    localparam int          STAGES    = 2;
    localparam realtime     TX_PERIOD = 10.0;
    localparam realtime     RX_PERIOD = 13.0;
    localparam int unsigned SEED      = 32'd20240611;

    logic tx_clk = 1'b0;
    logic rx_clk = 1'b0;
    logic rst_n  = 1'b0;
    bit   tx_run = 1'b0;
    bit   rx_run = 1'b0;
    logic tx_lost;
    logic rx_lost;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    xclk_loss_mon #(.LOSS_LIMIT(LIMIT), .SYNC_STAGES(STAGES)) u_xclk_loss_mon (
        .tx_clk      (tx_clk),
        .rx_clk      (rx_clk),
        .rst_n       (rst_n),
        .tx_clk_lost (tx_lost),
        .rx_clk_lost (rx_lost)
    );

    // Gated clock generators: a stopped clock keeps its last level.
    always begin
        #(TX_PERIOD / 2.0);
        if (tx_run) tx_clk = ~tx_clk;
    end
    always begin
        #(RX_PERIOD / 2.0);
        if (rx_run) rx_clk = ~rx_clk;
    end

    // Expected alarm k reference edges after the monitored clock stopped:
    // 0 = must be clear, 1 = must be raised, 2 = phase dependent.
    function automatic int stall_expect(input int k);
        if (k <= LIMIT)               return 0;
        if (k >= LIMIT + STAGES + 3)  return 1;
        return 2;
    endfunction

    // Reference edges after a restart by which the alarm must be clear.
    function automatic int clear_deadline();
        return STAGES + 3;
    endfunction

    // mon 0: transmit clock monitored, receive reference; mon 1: reverse.
    function automatic logic lost_of(input int mon);
        return (mon == 0) ? tx_lost : rx_lost;
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic ref_edge(input int mon);
        if (mon == 0) @(posedge rx_clk);
        else          @(posedge tx_clk);
        #1;
    endtask

    task automatic mon_edge(input int mon);
        if (mon == 0) @(posedge tx_clk);
        else          @(posedge rx_clk);
    endtask

    task automatic set_run(input int mon, input bit v);
        if (mon == 0) tx_run = v;
        else          rx_run = v;
    endtask

    // Stop one clock for n reference edges, check the alarm, then restart it.
    task automatic stall(input int mon, input int n);
        string hi_req;
        bit    long_stall;
        hi_req     = (mon == 0) ? "R1" : "R2";
        long_stall = (n >= LIMIT + STAGES + 3);
        mon_edge(mon);
        #1;
        set_run(mon, 1'b0);
        for (int k = 1; k <= n; k++) begin
            int e;
            ref_edge(mon);
            e = stall_expect(k);
            if (e == 0)
                check(long_stall ? hi_req : "R3", lost_of(mon), 1'b0);
            else if (e == 1)
                check((k == LIMIT + STAGES + 3) ? hi_req : "R5", lost_of(mon), 1'b1);
        end
        set_run(mon, 1'b1);
        mon_edge(mon);
        for (int k = 1; k <= clear_deadline(); k++) begin
            ref_edge(mon);
            if (k == clear_deadline())
                check("R4", lost_of(mon), 1'b0);
            else if (!long_stall)
                check("R3", lost_of(mon), 1'b0);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(2_000_000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        int unsigned seed_draw;
        seed_draw = $urandom(SEED);
        // R6: alarms low under reset with both clocks running.
        rst_n  = 1'b0;
        tx_run = 1'b1;
        rx_run = 1'b1;
        repeat (5) @(posedge rx_clk);
        repeat (5) @(posedge tx_clk);
        #1;
        check("R6", tx_lost, 1'b0);
        check("R6", rx_lost, 1'b0);
        #3 rst_n = 1'b1;
        // R3: no alarm while both clocks keep running.
        for (int k = 0; k < 30; k++) begin
            ref_edge(0);
            check("R3", tx_lost, 1'b0);
            check("R3", rx_lost, 1'b0);
        end
        // Directed corners: exact must-alarm bound, short pause, long saturation.
        stall(0, LIMIT + STAGES + 3);
        stall(1, LIMIT + STAGES + 3);
        stall(0, LIMIT - 3);
        stall(1, 1);
        stall(1, LIMIT - 3);
        stall(0, 4 * LIMIT);
        // Random stall lengths on random sides, far from the phase-dependent band.
        for (int i = 0; i < 24; i++) begin
            int mon;
            int n;
            mon = int'($urandom % 2);
            if ($urandom % 2)
                n = LIMIT + STAGES + 3 + int'($urandom % 20);
            else
                n = 1 + int'($urandom % (LIMIT - 3));
            stall(mon, n);
        end
        // R6: reset clears a raised alarm even while the clock is still stopped.
        @(posedge tx_clk);
        #1 tx_run = 1'b0;
        repeat (LIMIT + STAGES + 4) ref_edge(0);
        check("R1", tx_lost, 1'b1);
        rst_n = 1'b0;
        ref_edge(0);
        check("R6", tx_lost, 1'b0);
        ref_edge(0);
        check("R6", tx_lost, 1'b0);
        rst_n  = 1'b1;
        tx_run = 1'b1;
        repeat (3) @(posedge tx_clk);
        for (int k = 0; k < 2 * LIMIT; k++) begin
            ref_edge(0);
            check("R3", tx_lost, 1'b0);
        end
        done = 1'b1;
        summary();
        $finish;
    end

endmodule